// File: doc/BRIEF.md
# Two-Tier Idle Power Controller

This block manages the power state of one logic domain. It starts in the fully active state. When the domain reports idle, the controller first stops the domain clock. It does this through a gated clock output whose enable is held in a latch that is transparent while the clock is low. Entering and leaving this clock-stopped state costs no latency, and every register in the domain keeps its contents.

If the idle stretch lasts past a programmable break-even count, software has granted permission, and the domain is not marked latency-critical, the controller escalates to power gating. The sequence is:

1. Pulse a save strobe to the always-on retention latches. Isolation rises in the same cycle.
2. Switch the supply off on the next cycle.

A wake request brings the domain back in a fixed order:

1. Turn the supply on.
2. Wait for rail-good, or for a settle timeout. The timeout sets a sticky error flag.
3. Pulse the restore strobe.
4. Return to the active state, where isolation drops and the clock runs again.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: After reset the controller is active: ready_o=1, clk_en_o=1, pwr_en_o=1, iso_o=0, save_o=0, restore_o=0, settle_err_o=0.
- R2: In the active state, idle_i=1 with wake_i=0 moves the controller to clock-gated at the next edge: clk_en_o and ready_o both fall in that cycle and pwr_en_o stays 1. With wake_i=1 it stays active.
- R3: gclk_o pulses only on clock edges where the latched enable is 1. The latch samples clk_en_o while clk_i is low. So the high phase right after leaving the active state still pulses, and later high phases do not.
- R4: With idle_i held, pg_permit_i=1 and no_pg_i=0, the controller stays clock-gated for exactly T+1 cycles, where T is idle_thresh_i, and then enters the save state.
- R5: While no_pg_i=1 or pg_permit_i=0, the controller stays in the clock-gated state however long idle lasts.
- R6: In the clock-gated state, wake_i=1 or idle_i=0 returns the controller to active at the next edge and clears the idle count. A later idle stretch needs the full T+1 cycles again.
- R7: The save state lasts one cycle, with save_o=1, iso_o=1 and pwr_en_o=1. The next cycle has pwr_en_o=0 and iso_o=1, so isolation leads supply-off by one cycle.
- R8: With the supply off, the controller waits without limit for wake_i=1. wake_i=1 turns pwr_en_o on at the next edge, with iso_o=1 and clk_en_o=0.
- R9: In the settle state, rail_good_i=1 leads at the next edge to a one-cycle restore_o=1 pulse, with iso_o=1 and clk_en_o=0. After that the controller is active.
- R10: If rail_good_i stays 0, the settle state lasts 2^SETTLE_W cycles (1024 by default). The restore strobe then follows, and settle_err_o goes to 1 and stays there until reset.
- R11: ready_o is 1 only in the active state. iso_o falls and clk_en_o rises only on entry to the active state after the restore strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_i | input | 1 | Domain reports idle |
| wake_i | input | 1 | Wake request (level) |
| idle_thresh_i | input | THRESH_W | Break-even idle count T |
| pg_permit_i | input | 1 | Software permission to power gate |
| no_pg_i | input | 1 | Latency-critical mode: clock gating only |
| rail_good_i | input | 1 | Domain rail has settled |
| gclk_o | output | 1 | Gated domain clock |
| clk_en_o | output | 1 | Clock enable request, before the latch |
| pwr_en_o | output | 1 | Supply switch enable |
| iso_o | output | 1 | Output isolation enable |
| save_o | output | 1 | Retention save strobe |
| restore_o | output | 1 | Retention restore strobe |
| ready_o | output | 1 | Domain fully active |
| settle_err_o | output | 1 | Sticky rail-settle timeout flag |

## Verification
The bench sweeps the threshold from 0 upward and counts clock-gated cycles. A counter compared off by one would make the save strobe arrive a cycle early or late. It cuts a stretch short with a wake and then re-idles. An idle count that is not cleared would escalate too soon. It keeps no_pg_i or a withdrawn permit in force for long stretches. A controller that ignores either would start a save sequence. It also varies the rail-good delay, runs the full settle timeout once, and samples the gated clock in the high phase around each transition. These catch a misordered isolation or restore, an error flag that is not sticky, and an ungated or mistimed clock pulse.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_CGATE,
    ST_SAVE,
    ST_OFF,
    ST_PWRUP,
    ST_RESTORE
  } ipc_state_e;
endpackage

// File: rtl/ipc_idle_cnt.sv
module ipc_idle_cnt #(
  parameter int unsigned THRESH_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic [THRESH_W-1:0] thresh_i,
  output logic                reached_o
);
  localparam logic [THRESH_W-1:0] CntMax = '1;

  logic [THRESH_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  assign reached_o = run_i && (cnt_q >= thresh_i);
endmodule

// File: rtl/ipc_settle_tmr.sv
module ipc_settle_tmr #(
  parameter int unsigned SETTLE_W = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam logic [SETTLE_W-1:0] TmrLast = '1;

  logic [SETTLE_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tmr_q <= '0;
    else if (!run_i) tmr_q <= '0;
    else             tmr_q <= tmr_q + 1'b1;
  end

  assign expired_o = run_i && (tmr_q == TmrLast);
endmodule

// File: rtl/ipc_clk_gate.sv
module ipc_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lat;

  // transparent in low phase: enable frozen while clk_i is high
  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/ipc_fsm.sv
module ipc_fsm
  import ipc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic wake_i,
  input  logic pg_permit_i,
  input  logic no_pg_i,
  input  logic rail_good_i,
  input  logic thresh_hit_i,
  input  logic settle_tmo_i,
  output logic cnt_run_o,
  output logic tmr_run_o,
  output logic clk_en_o,
  output logic pwr_en_o,
  output logic iso_o,
  output logic save_o,
  output logic restore_o,
  output logic ready_o,
  output logic settle_err_o
);
  ipc_state_e state_q, state_d;
  logic       err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE:  if (idle_i && !wake_i) state_d = ST_CGATE;
      ST_CGATE: begin
        if (wake_i || !idle_i)                          state_d = ST_ACTIVE;
        else if (thresh_hit_i && pg_permit_i && !no_pg_i) state_d = ST_SAVE;
      end
      ST_SAVE:    state_d = ST_OFF;
      ST_OFF:     if (wake_i) state_d = ST_PWRUP;
      ST_PWRUP:   if (rail_good_i || settle_tmo_i) state_d = ST_RESTORE;
      ST_RESTORE: state_d = ST_ACTIVE;
      default:    state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACTIVE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_PWRUP && !rail_good_i && settle_tmo_i) err_q <= 1'b1;
    end
  end

  assign cnt_run_o    = (state_q == ST_CGATE);
  assign tmr_run_o    = (state_q == ST_PWRUP);
  assign ready_o      = (state_q == ST_ACTIVE);
  assign clk_en_o     = (state_q == ST_ACTIVE);
  assign pwr_en_o     = (state_q != ST_OFF);
  assign iso_o        = (state_q == ST_SAVE) || (state_q == ST_OFF) ||
                        (state_q == ST_PWRUP) || (state_q == ST_RESTORE);
  assign save_o       = (state_q == ST_SAVE);
  assign restore_o    = (state_q == ST_RESTORE);
  assign settle_err_o = err_q;
endmodule

// File: rtl/idle_pwr_ctrl.sv
module idle_pwr_ctrl #(
  parameter int unsigned THRESH_W = 16,
  parameter int unsigned SETTLE_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                idle_i,
  input  logic                wake_i,
  input  logic [THRESH_W-1:0] idle_thresh_i,
  input  logic                pg_permit_i,
  input  logic                no_pg_i,
  input  logic                rail_good_i,
  output logic                gclk_o,
  output logic                clk_en_o,
  output logic                pwr_en_o,
  output logic                iso_o,
  output logic                save_o,
  output logic                restore_o,
  output logic                ready_o,
  output logic                settle_err_o
);
  logic cnt_run, tmr_run, thresh_hit, settle_tmo, clk_en;

  ipc_idle_cnt #(.THRESH_W(THRESH_W)) u_idle_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (cnt_run),
    .thresh_i  (idle_thresh_i),
    .reached_o (thresh_hit)
  );

  ipc_settle_tmr #(.SETTLE_W(SETTLE_W)) u_settle_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (tmr_run),
    .expired_o (settle_tmo)
  );

  ipc_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idle_i       (idle_i),
    .wake_i       (wake_i),
    .pg_permit_i  (pg_permit_i),
    .no_pg_i      (no_pg_i),
    .rail_good_i  (rail_good_i),
    .thresh_hit_i (thresh_hit),
    .settle_tmo_i (settle_tmo),
    .cnt_run_o    (cnt_run),
    .tmr_run_o    (tmr_run),
    .clk_en_o     (clk_en),
    .pwr_en_o     (pwr_en_o),
    .iso_o        (iso_o),
    .save_o       (save_o),
    .restore_o    (restore_o),
    .ready_o      (ready_o),
    .settle_err_o (settle_err_o)
  );

  ipc_clk_gate u_clk_gate (
    .clk_i  (clk_i),
    .en_i   (clk_en),
    .gclk_o (gclk_o)
  );

  assign clk_en_o = clk_en;
endmodule

// File: rtl/idle_pwr_ctrl_chk.sv
module idle_pwr_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic no_pg_i,
  input logic clk_en_o,
  input logic pwr_en_o,
  input logic iso_o,
  input logic save_o,
  input logic restore_o,
  input logic ready_o,
  input logic settle_err_o
);
  // R7
  iso_leads_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_en_o) |-> $past(iso_o) && $past(save_o));

  // R7
  save_then_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |=> !pwr_en_o && iso_o);

  // R5
  no_pg_blocks_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(no_pg_i) && !$past(save_o) |-> !save_o);

  // R9
  restore_powered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |-> pwr_en_o && iso_o && !clk_en_o);

  // R9
  restore_then_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |=> ready_o && clk_en_o && !iso_o);

  // R11
  ready_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> clk_en_o && pwr_en_o && !iso_o);

  // R11
  strobes_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({save_o, restore_o, ready_o}));

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(settle_err_o) |-> settle_err_o);
endmodule

bind idle_pwr_ctrl idle_pwr_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .no_pg_i      (no_pg_i),
  .clk_en_o     (clk_en_o),
  .pwr_en_o     (pwr_en_o),
  .iso_o        (iso_o),
  .save_o       (save_o),
  .restore_o    (restore_o),
  .ready_o      (ready_o),
  .settle_err_o (settle_err_o)
);

// File: tb/idle_pwr_ctrl_tb.sv
module idle_pwr_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;
  localparam int SW = 10;
  localparam int SETTLE_CYC = 1 << SW;

  // bench-side state codes
  localparam int S_ACT = 0, S_CG = 1, S_SAVE = 2, S_OFF = 3, S_UP = 4, S_RST = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic idle = 1'b0, wake = 1'b0, permit = 1'b1, no_pg = 1'b0, rail = 1'b0;
  logic [TW-1:0] thresh = '0;
  logic gclk, clk_en, pwr_en, iso, save, restore, ready, err;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_pwr_ctrl #(.THRESH_W(TW), .SETTLE_W(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .idle_i(idle), .wake_i(wake),
    .idle_thresh_i(thresh), .pg_permit_i(permit), .no_pg_i(no_pg),
    .rail_good_i(rail), .gclk_o(gclk), .clk_en_o(clk_en), .pwr_en_o(pwr_en),
    .iso_o(iso), .save_o(save), .restore_o(restore), .ready_o(ready),
    .settle_err_o(err)
  );

  // {ready, clk_en, pwr_en, iso, save, restore}
  function automatic logic [5:0] exp_of(int s);
    case (s)
      S_ACT:   return 6'b111000;
      S_CG:    return 6'b001000;
      S_SAVE:  return 6'b001110;
      S_OFF:   return 6'b000100;
      S_UP:    return 6'b001100;
      default: return 6'b001101;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_st(string req, int s);
    logic [5:0] act;
    act = {ready, clk_en, pwr_en, iso, save, restore};
    n_chk++;
    if (act !== exp_of(s)) begin
      n_err++;
      $display("FAIL %s: outputs act=%b exp=%b", req, act, exp_of(s));
    end
  endtask

  task automatic chk1(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: %s act=%b exp=%b", req, what, act, exp);
    end
  endtask

  // from OFF back to ACTIVE with rail good after d cycles
  task automatic wake_back(int d);
    wake = 1'b1;
    tick(); chk_st("R8", S_UP);
    wake = 1'b0;
    for (int i = 0; i < d; i++) begin
      tick(); chk_st("R9", S_UP);
    end
    rail = 1'b1;
    tick(); chk_st("R9", S_RST);
    rail = 1'b0;
    idle = 1'b0;
    tick(); chk_st("R11", S_ACT);
    chk1("R3", "gclk after restore edge", gclk, 1'b0);
    tick(); chk1("R3", "gclk when active", gclk, 1'b1);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    chk_st("R1", S_ACT);
    chk1("R1", "settle_err", err, 1'b0);
    tick(); chk1("R3", "gclk active", gclk, 1'b1);

    // threshold sweep
    for (int t = 0; t <= 9; t++) begin
      thresh = TW'(t);
      idle = 1'b1;
      tick(); chk_st("R2", S_CG);
      chk1("R3", "gclk on leaving edge", gclk, 1'b1);
      for (int i = 0; i < t; i++) begin
        tick(); chk_st("R4", S_CG);
      end
      tick(); chk_st("R4", S_SAVE);
      chk1("R3", "gclk while gated", gclk, 1'b0);
      tick(); chk_st("R7", S_OFF);
      for (int i = 0; i < 3; i++) begin
        tick(); chk_st("R8", S_OFF);
      end
      wake_back(t % 4);
    end

    // wake in ACTIVE has priority over idle
    idle = 1'b1; wake = 1'b1;
    tick(); chk_st("R2", S_ACT);
    wake = 1'b0;

    // wake in CG clears the count
    thresh = TW'(4);
    tick(); chk_st("R2", S_CG);
    for (int i = 0; i < 3; i++) begin
      tick(); chk_st("R6", S_CG);
    end
    wake = 1'b1;
    tick(); chk_st("R6", S_ACT);
    wake = 1'b0;
    tick(); chk_st("R6", S_CG);
    for (int i = 0; i < 4; i++) begin
      tick(); chk_st("R6", S_CG);
    end
    tick(); chk_st("R6", S_SAVE);
    tick(); chk_st("R7", S_OFF);
    wake_back(0);

    // idle drop in CG
    idle = 1'b1;
    tick(); chk_st("R2", S_CG);
    idle = 1'b0;
    tick(); chk_st("R6", S_ACT);

    // latency-critical and no-permit hold CG
    thresh = TW'(2); no_pg = 1'b1; idle = 1'b1;
    tick(); chk_st("R2", S_CG);
    for (int i = 0; i < 40; i++) begin
      tick(); chk_st("R5", S_CG);
    end
    no_pg = 1'b0; permit = 1'b0;
    for (int i = 0; i < 20; i++) begin
      tick(); chk_st("R5", S_CG);
    end
    permit = 1'b1;
    tick(); chk_st("R4", S_SAVE);
    tick(); chk_st("R7", S_OFF);

    // settle timeout
    wake = 1'b1;
    tick(); chk_st("R8", S_UP);
    wake = 1'b0;
    for (int i = 0; i < SETTLE_CYC - 1; i++) tick();
    chk_st("R10", S_UP);
    chk1("R10", "settle_err before timeout", err, 1'b0);
    tick(); chk_st("R10", S_RST);
    chk1("R10", "settle_err at timeout", err, 1'b1);
    idle = 1'b0;
    tick(); chk_st("R11", S_ACT);
    chk1("R10", "settle_err sticky", err, 1'b1);

    // normal cycle afterwards keeps error
    thresh = TW'(1); idle = 1'b1;
    tick(); chk_st("R2", S_CG);
    tick(); chk_st("R4", S_CG);
    tick(); chk_st("R4", S_SAVE);
    tick(); chk_st("R7", S_OFF);
    wake_back(2);
    chk1("R10", "settle_err sticky after good wake", err, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule